// File: doc/BRIEF.md
# Masked Level-Sensitive Interrupt Gate

This block sits inside a processor core, between the interrupt request lines and the exception logic. It receives one level-sensitive request line per source and passes each through a two-stage synchronizer. It then masks the synchronized levels with a per-source enable mask. The result is a pending vector. A single interrupt request to the core is raised while a global enable bit is set and at least one pending bit is 1.

No hardware ranking of sources is done. Software reads the pending vector through the control-register port and chooses which source to serve. The same port writes and reads back the enable mask and the global enable bit. Requests are levels and are never latched: once a source drops its line, its pending bit clears two cycles later.

Top module: `irq_gate`

## Requirements
- R1: There are 32 request inputs, numbered 0 to 31. Pending bit n depends only on input n and enable bit n.
- R2: Each input passes through two flip-flops. A change at an input shows on the pending vector after exactly two rising clock edges. A change seen after only one edge is an error. Inputs are levels: no request is latched.
- R3: Register select 2'b00 is the enable mask. A write stores all 32 data bits, one enable per source. A read returns the stored mask.
- R4: Register select 2'b01 is the status register. Only bit 0, the global enable, is stored. A read returns zero in bits 31..1, and writes to those bits have no effect.
- R5: The request output `irq_req` is 1 if and only if the global enable is 1 and some bit n has both the synchronized input n and enable bit n set. It is driven combinationally from registered state, so it falls in the same cycle the condition stops holding.
- R6: Register select 2'b10 reads the pending vector, which is the synchronized inputs ANDed with the enable mask, whatever the global enable is. A write to this select changes no state.
- R7: Register select 2'b11 reads as zero, and a write to it changes no state.
- R8: Reset clears the enable mask, the global enable and the synchronizer. After reset, every register reads zero and `irq_req` is 0.
- R9: No priority is applied. When several sources are pending at once, every one of them appears in the pending vector, and `irq_req` is 1 when the global enable is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | 32 | Level-sensitive request lines, one per source |
| csr_sel | input | 2 | Register select: 00 enable, 01 status, 10 pending, 11 reserved |
| csr_we | input | 1 | Write strobe, sampled on the rising clock edge |
| csr_wdata | input | 32 | Write data |
| csr_rdata | output | 32 | Read data for the selected register, combinational |
| pending | output | 32 | Synchronized requests masked by the enable register |
| irq_req | output | 1 | Interrupt request to the exception logic |

## Verification
The assertions check a number of rules on every cycle:
- each synchronizer stage holds its input from the previous edge;
- writes to the enable and status selects land in the register;
- writes to the pending and reserved selects leave all state unchanged;
- no pending bit is set without its enable bit;
- `irq_req` follows the global enable and the pending vector in both directions.

Only the bench's scenarios can show some other behaviour:
- the exact two-edge latency seen from the ports;
- that each of the 32 sources reaches only its own pending bit;
- that several sources are reported together;
- that requests stay levels and are never latched;
- the values read back after reset.

// File: rtl/irq_gate_pkg.sv
package irq_gate_pkg;

    localparam int CSR_W   = 32;
    localparam int GIE_BIT = 0;

    typedef enum logic [1:0] {
        SEL_ENABLE  = 2'b00,
        SEL_STATUS  = 2'b01,
        SEL_PENDING = 2'b10,
        SEL_RSVD    = 2'b11
    } csr_sel_e;

endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
    parameter int W      = 32,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    typedef struct packed {
        logic [STAGES-1:0][W-1:0] stg;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.stg[0] = din;
        for (int i = 1; i < STAGES; i++) begin
            st_d.stg[i] = st_q.stg[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign dout = st_q.stg[STAGES-1];

    AST_SYNC_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.stg[0] == $past(din)); // R2

    generate
        if (STAGES >= 2) begin : g_chain_chk
            AST_SYNC_CHAIN: assert property (@(posedge clk) disable iff (!rst_n)
                dout == $past(st_q.stg[STAGES-2])); // R2
        end
    endgenerate

endmodule

// File: rtl/irq_csr.sv
module irq_csr
    import irq_gate_pkg::*;
#(
    parameter int NUM_SRC = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [1:0]         sel,
    input  logic               we,
    input  logic [CSR_W-1:0]   wdata,
    input  logic [NUM_SRC-1:0] pend,
    output logic [NUM_SRC-1:0] enable,
    output logic               gie,
    output logic [CSR_W-1:0]   rdata
);

    typedef struct packed {
        logic [NUM_SRC-1:0] en;
        logic               gie;
    } csr_t;

    csr_t cs_d, cs_q;

    always_comb begin
        cs_d = cs_q;
        if (we) begin
            case (csr_sel_e'(sel))
                SEL_ENABLE: cs_d.en  = wdata[NUM_SRC-1:0];
                SEL_STATUS: cs_d.gie = wdata[GIE_BIT];
                default:    cs_d     = cs_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_q <= '0;
        end else begin
            cs_q <= cs_d;
        end
    end

    always_comb begin
        rdata = '0;
        case (csr_sel_e'(sel))
            SEL_ENABLE:  rdata[NUM_SRC-1:0] = cs_q.en;
            SEL_STATUS:  rdata[GIE_BIT]     = cs_q.gie;
            SEL_PENDING: rdata[NUM_SRC-1:0] = pend;
            default:     rdata              = '0;
        endcase
    end

    assign enable = cs_q.en;
    assign gie    = cs_q.gie;

    AST_EN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (we && sel == SEL_ENABLE) |=> enable == $past(wdata[NUM_SRC-1:0])); // R3
    AST_GIE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (we && sel == SEL_STATUS) |=> gie == $past(wdata[GIE_BIT])); // R4
    AST_PEND_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (we && sel == SEL_PENDING) |=> ($stable(enable) && $stable(gie))); // R6
    AST_RSVD_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (we && sel == SEL_RSVD) |=> ($stable(enable) && $stable(gie))); // R7

endmodule

// File: rtl/irq_combine.sv
module irq_combine #(
    parameter int NUM_SRC = 32
) (
    input  logic [NUM_SRC-1:0] req_sync,
    input  logic [NUM_SRC-1:0] enable,
    input  logic               gie,
    output logic [NUM_SRC-1:0] pending,
    output logic               irq_req
);

    logic [NUM_SRC-1:0] masked;

    genvar g;
    generate
        for (g = 0; g < NUM_SRC; g++) begin : g_src
            assign masked[g] = req_sync[g] & enable[g];
        end
    endgenerate

    assign pending = masked;
    assign irq_req = gie & (|masked);

endmodule

// File: rtl/irq_gate.sv
module irq_gate
    import irq_gate_pkg::*;
#(
    parameter int NUM_SRC     = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] irq_in,
    input  logic [1:0]         csr_sel,
    input  logic               csr_we,
    input  logic [CSR_W-1:0]   csr_wdata,
    output logic [CSR_W-1:0]   csr_rdata,
    output logic [NUM_SRC-1:0] pending,
    output logic               irq_req
);

    logic [NUM_SRC-1:0] req_sync;
    logic [NUM_SRC-1:0] enable;
    logic               gie;

    irq_sync #(.W(NUM_SRC), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (irq_in),
        .dout  (req_sync)
    );

    irq_csr #(.NUM_SRC(NUM_SRC)) u_csr (
        .clk    (clk),
        .rst_n  (rst_n),
        .sel    (csr_sel),
        .we     (csr_we),
        .wdata  (csr_wdata),
        .pend   (pending),
        .enable (enable),
        .gie    (gie),
        .rdata  (csr_rdata)
    );

    irq_combine #(.NUM_SRC(NUM_SRC)) u_comb (
        .req_sync (req_sync),
        .enable   (enable),
        .gie      (gie),
        .pending  (pending),
        .irq_req  (irq_req)
    );

    AST_IRQ_NEEDS_GIE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> gie); // R5
    AST_IRQ_WHEN_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        (gie && pending != '0) |-> irq_req); // R5
    AST_IRQ_NEEDS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> (pending != '0)); // R9
    AST_PEND_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (pending & ~enable) == '0); // R6

endmodule

// File: tb/irq_gate_test.sv
module irq_gate_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] irq_in = '0;
    logic [1:0]  csr_sel = 2'b00;
    logic        csr_we = 1'b0;
    logic [31:0] csr_wdata = '0;
    logic [31:0] csr_rdata;
    logic [31:0] pending;
    logic        irq_req;

    int checks = 0;
    int failures = 0;
    int cyc = 0;

    always #5 clk = ~clk;

    irq_gate uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .irq_in    (irq_in),
        .csr_sel   (csr_sel),
        .csr_we    (csr_we),
        .csr_wdata (csr_wdata),
        .csr_rdata (csr_rdata),
        .pending   (pending),
        .irq_req   (irq_req)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            failures = failures + 1;
            $display("FAIL watchdog: run did not finish, got cycle %0d expected < 150000", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks = checks + 1;
        if (act !== exp) begin
            failures = failures + 1;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic csr_wr(input logic [1:0] s, input logic [31:0] d);
        @(negedge clk);
        csr_sel = s; csr_wdata = d; csr_we = 1'b1;
        @(negedge clk);
        csr_we = 1'b0; csr_wdata = '0;
    endtask

    task automatic csr_rd(input logic [1:0] s, output logic [31:0] d);
        csr_sel = s;
        #1;
        d = csr_rdata;
    endtask

    // drive at a negative edge, let two rising edges pass, sample at the next negative edge
    task automatic drive_settle(input logic [31:0] v);
        @(negedge clk);
        irq_in = v;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        logic [31:0] rd;
        logic [31:0] en_v;
        logic [31:0] in_v;
        logic [31:0] lfsr;

        repeat (3) @(negedge clk);
        // R8: register values while held in reset and just after release
        csr_rd(2'b00, rd); chk("R8 enable after reset", rd, 32'h0);
        rst_n = 1'b1;
        irq_in = 32'hFFFF_FFFF;
        @(posedge clk); @(posedge clk); @(negedge clk);
        csr_rd(2'b00, rd); chk("R8 enable reads zero", rd, 32'h0);
        csr_rd(2'b01, rd); chk("R8 status reads zero", rd, 32'h0);
        csr_rd(2'b10, rd); chk("R8 pending zero with mask clear", rd, 32'h0);
        chk("R8 irq_req low", {31'b0, irq_req}, 32'h0);
        irq_in = '0;

        // R3 enable register write/readback
        csr_wr(2'b00, 32'hA5C3_0F96);
        csr_rd(2'b00, rd); chk("R3 enable readback", rd, 32'hA5C3_0F96);
        // R4 status: only bit 0 stored
        csr_wr(2'b01, 32'hFFFF_FFFE);
        csr_rd(2'b01, rd); chk("R4 status upper bits ignored", rd, 32'h0);
        csr_wr(2'b01, 32'hFFFF_FFFF);
        csr_rd(2'b01, rd); chk("R4 status gie set", rd, 32'h1);

        // R1 per-source sweep, one-hot enable, all inputs high
        for (int n = 0; n < 32; n++) begin
            en_v = 32'h1 << n;
            csr_wr(2'b00, en_v);
            drive_settle(32'hFFFF_FFFF);
            chk($sformatf("R1 pending src %0d", n), pending, en_v);
            chk($sformatf("R5 irq src %0d", n), {31'b0, irq_req}, 32'h1);
            // input n low, others high: nothing pending
            drive_settle(~en_v);
            chk($sformatf("R1 isolation src %0d", n), pending, 32'h0);
            chk($sformatf("R5 irq off src %0d", n), {31'b0, irq_req}, 32'h0);
        end

        // R2 latency: pending must not change after one edge only
        csr_wr(2'b00, 32'hFFFF_FFFF);
        drive_settle(32'h0);
        @(negedge clk);
        irq_in = 32'h0000_0810;
        @(posedge clk); @(negedge clk);
        chk("R2 no change after one edge", pending, 32'h0);
        @(posedge clk); @(negedge clk);
        chk("R2 change after two edges", pending, 32'h0000_0810);
        // R2 level, not latched
        drive_settle(32'h0);
        chk("R2 pending clears when line drops", pending, 32'h0);

        // R9 and R6 pattern sweep with computed expected values
        lfsr = 32'hACE1_2468;
        for (int k = 0; k < 40; k++) begin
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            en_v = lfsr;
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            in_v = lfsr ^ 32'h3C3C_5A5A;
            csr_wr(2'b01, {31'b0, k[0]});
            csr_wr(2'b00, en_v);
            drive_settle(in_v);
            csr_rd(2'b10, rd);
            chk($sformatf("R6 pending read pattern %0d", k), rd, in_v & en_v);
            chk($sformatf("R9 pending port pattern %0d", k), pending, in_v & en_v);
            chk($sformatf("R5 irq pattern %0d", k), {31'b0, irq_req},
                {31'b0, k[0] & ((in_v & en_v) != 0)});
        end

        // R5 immediate drop on clearing gie
        csr_wr(2'b00, 32'hFFFF_FFFF);
        csr_wr(2'b01, 32'h1);
        drive_settle(32'h8000_0001);
        chk("R9 two sources pending", pending, 32'h8000_0001);
        chk("R5 irq high", {31'b0, irq_req}, 32'h1);
        @(negedge clk);
        csr_sel = 2'b01; csr_wdata = 32'h0; csr_we = 1'b1;
        @(posedge clk); #1;
        chk("R5 irq drops right after gie clear", {31'b0, irq_req}, 32'h0);
        @(negedge clk); csr_we = 1'b0;
        chk("R6 pending kept without gie", pending, 32'h8000_0001);

        // R6 writes to pending select ignored
        csr_wr(2'b10, 32'h0);
        csr_rd(2'b00, rd); chk("R6 write to pending keeps enable", rd, 32'hFFFF_FFFF);
        csr_rd(2'b01, rd); chk("R6 write to pending keeps status", rd, 32'h0);
        chk("R6 pending after write", pending, 32'h8000_0001);
        // R7 reserved select
        csr_wr(2'b11, 32'h0);
        csr_rd(2'b11, rd); chk("R7 reserved reads zero", rd, 32'h0);
        csr_rd(2'b00, rd); chk("R7 reserved write keeps enable", rd, 32'hFFFF_FFFF);
        csr_wr(2'b11, 32'h1);
        csr_rd(2'b01, rd); chk("R7 reserved write keeps status", rd, 32'h0);

        // R8 reset mid-run clears state
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        irq_in = '0;
        csr_rd(2'b00, rd); chk("R8 enable cleared by reset", rd, 32'h0);
        chk("R8 pending cleared by reset", pending, 32'h0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule